// File: doc/BRIEF.md
# Serial Sampling Converter Output Emulator

This block models the digital side of a 16-bit sampling converter behind a three-wire serial link, so that host logic which reads such a converter can be exercised without the analog part. The host owns the data clock and an active-low select. The bench presents a sample word that stands for the analog input. Pulling the select low starts a frame. The block leaves its data pin undriven while the input is "sampled", then drives one low null bit. It then shifts the word out most significant bit first, repeats it least significant bit first, and releases the pin.

Every output transition follows a falling edge of the data clock, so the host can capture on rising edges. The frame's position is kept by a falling-edge counter that the select clears asynchronously. Raising the select at any moment therefore aborts the frame, which allows short cycling. The sample word is captured when the select falls, and the bits shifted out are always those of the current frame, with no pipeline delay. A two-bit status reports whether the model is active, in analog-only power-down, or in full power-down.

Top module: `sar_serial_emu`

## Requirements
- R1: Whenever cs_n is high, sdo_en is 0 and pwr_state is 2'b10 (full power-down). This holds at once, also when cs_n rises in the middle of a frame.
- R2: A falling edge of cs_n starts a frame and captures sample_word. Changes to sample_word later in the same frame do not alter the bits shifted out in that frame.
- R3: Between the falling edge of cs_n and the 5th falling edge of dclk, sdo_en stays 0.
- R4: After the 5th falling dclk edge of a frame, sdo_en is 1 and sdo is 0 (null bit) for one clock period.
- R5: After falling edge n, for n from 6 to 21, sdo carries bit 21-n of the captured word. This gives B15 (MSB) first down to B0, in straight binary.
- R6: After falling edge n, for n from 22 to 36, sdo carries bit n-21 of the captured word. This repeats the word LSB-first, from B1 up to B15.
- R7: From the 37th falling dclk edge on, sdo_en is 0, and further dclk edges have no effect until cs_n goes high and low again.
- R8: While cs_n is low, pwr_state is 2'b00 (active) before the 21st falling dclk edge and 2'b01 (analog power-down) from the 21st edge on. Once it reads 2'b01 it keeps that value until cs_n rises.
- R9: Each new cs_n high-then-low cycle starts a fresh frame from the null-bit sequence, using the word presented at that new falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dclk | input | 1 | Data clock from the host; outputs change after its falling edges |
| cs_n | input | 1 | Active-low select; low starts a frame, high aborts it and powers down |
| sample_word | input | 16 | Word that stands for the analog input, captured when cs_n falls |
| sdo | output | 1 | Serial data bit, valid while sdo_en is 1 |
| sdo_en | output | 1 | Output enable of the modelled tri-state pin |
| pwr_state | output | 2 | 00 active, 01 analog power-down, 10 full power-down |

## Verification
Two functions can land in the same instant. The first pair is the select rising to abort a frame and a falling data-clock edge that would advance it. The bench raises cs_n in the very timestep of a falling dclk edge, at random frame positions and at directed ones. It then judges that the enable is low and the status reads full power-down, whichever process runs first. The second pair is word capture and a host update of the sample word. The bench rewrites sample_word a few edges after the select falls and expects the frame to carry only the word that was present at the fall.

// File: rtl/sar_emu_pkg.sv
`timescale 1ns/1ps
package sar_emu_pkg;

   typedef enum logic [1:0] {
      PWR_ON     = 2'b00,
      PWR_ANALOG = 2'b01,
      PWR_FULL   = 2'b10
   } pwr_e;

   // number of falling edges after which the frame is over
   function automatic int frame_end(input int data_w, input int sample_edges, input int null_bits,
                                    input bit repeat_lsb);
      return sample_edges + null_bits + data_w + (repeat_lsb ? data_w - 1 : 0);
   endfunction

endpackage

// File: rtl/sar_emu_edge_cnt.sv
`timescale 1ns/1ps
module sar_emu_edge_cnt #(
   parameter int CNT_W   = 6,
   parameter int END_CNT = 37
) (
   input  logic             dclk,
   input  logic             cs_n,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] END_C = CNT_W'(END_CNT);
   localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

   if (END_CNT >= (1 << CNT_W)) begin : g_bad_width
      $error("edge counter too narrow for frame length");
   end

   // select high clears the frame phase at any time
   always_ff @(negedge dclk or posedge cs_n) begin
      if (cs_n)
         cnt <= '0;
      else if (cnt != END_C)
         cnt <= cnt + ONE_C;
   end
endmodule

// File: rtl/sar_emu_word_latch.sv
`timescale 1ns/1ps
module sar_emu_word_latch #(
   parameter int DATA_W = 16
) (
   input  logic              cs_n,
   input  logic [DATA_W-1:0] sample_in,
   output logic [DATA_W-1:0] word_q
);
   always_ff @(negedge cs_n) begin
      word_q <= sample_in;
   end
endmodule

// File: rtl/sar_emu_out_sel.sv
`timescale 1ns/1ps
module sar_emu_out_sel
   import sar_emu_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int SAMPLE_EDGES = 5,
   parameter int NULL_BITS    = 1,
   parameter bit REPEAT_LSB   = 1'b1,
   parameter int CNT_W        = 6
) (
   input  logic              cs_n,
   input  logic [CNT_W-1:0]  cnt,
   input  logic [DATA_W-1:0] word_q,
   output logic              sdo,
   output logic              sdo_en,
   output pwr_e              pwr
);
   localparam int IDX_W = $clog2(DATA_W);
   localparam int FIRST = SAMPLE_EDGES + NULL_BITS;
   localparam logic [CNT_W-1:0] SAMPLE_C = CNT_W'(SAMPLE_EDGES);
   localparam logic [CNT_W-1:0] FIRST_C  = CNT_W'(FIRST);
   localparam logic [CNT_W-1:0] MSB_END  = CNT_W'(FIRST + DATA_W);
   localparam logic [CNT_W-1:0] DONE_C   = CNT_W'(FIRST + DATA_W - 1);
   localparam logic [CNT_W-1:0] DW_C     = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] ONE_C    = CNT_W'(1);
   localparam logic [IDX_W-1:0] TOP_IDX  = IDX_W'(DATA_W - 1);

   logic [CNT_W-1:0] offs;
   logic             null_hit, msb_hit, lsb_hit;
   logic [IDX_W-1:0] msb_idx, lsb_idx;

   assign offs     = cnt - FIRST_C;
   assign null_hit = (cnt >= SAMPLE_C) && (cnt < FIRST_C);
   assign msb_hit  = (cnt >= FIRST_C) && (cnt < MSB_END);
   assign msb_idx  = TOP_IDX - IDX_W'(offs);

   if (REPEAT_LSB) begin : g_repeat
      localparam logic [CNT_W-1:0] LSB_END = CNT_W'(FIRST + 2 * DATA_W - 1);
      assign lsb_hit = (cnt >= MSB_END) && (cnt < LSB_END);
      assign lsb_idx = IDX_W'(offs - DW_C + ONE_C);
   end else begin : g_single
      assign lsb_hit = 1'b0;
      assign lsb_idx = '0;
   end

   always_comb begin
      sdo_en = 1'b0;
      sdo    = 1'b0;
      if (!cs_n) begin
         if (null_hit) begin
            sdo_en = 1'b1;
         end else if (msb_hit) begin
            sdo_en = 1'b1;
            sdo    = word_q[msb_idx];
         end else if (lsb_hit) begin
            sdo_en = 1'b1;
            sdo    = word_q[lsb_idx];
         end
      end
   end

   always_comb begin
      if (cs_n)
         pwr = PWR_FULL;
      else if (cnt >= DONE_C)
         pwr = PWR_ANALOG;
      else
         pwr = PWR_ON;
   end
endmodule

// File: rtl/sar_serial_emu.sv
`timescale 1ns/1ps
module sar_serial_emu
   import sar_emu_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int SAMPLE_EDGES = 5,
   parameter int NULL_BITS    = 1,
   parameter bit REPEAT_LSB   = 1'b1
) (
   input  logic              dclk,
   input  logic              cs_n,
   input  logic [DATA_W-1:0] sample_word,
   output logic              sdo,
   output logic              sdo_en,
   output logic [1:0]        pwr_state
);
   localparam int END_CNT = frame_end(DATA_W, SAMPLE_EDGES, NULL_BITS, REPEAT_LSB);
   localparam int CNT_W   = $clog2(END_CNT + 1);

   if (DATA_W < 2) begin : g_bad_data
      $error("DATA_W must be at least 2");
   end
   if (SAMPLE_EDGES < 1) begin : g_bad_sample
      $error("SAMPLE_EDGES must be at least 1");
   end
   if (NULL_BITS < 0) begin : g_bad_null
      $error("NULL_BITS must not be negative");
   end

   logic [CNT_W-1:0]  edge_cnt;
   logic [DATA_W-1:0] word_q;
   pwr_e              pwr;

   sar_emu_edge_cnt #(.CNT_W(CNT_W), .END_CNT(END_CNT)) u_cnt (
      .dclk (dclk),
      .cs_n (cs_n),
      .cnt  (edge_cnt)
   );

   sar_emu_word_latch #(.DATA_W(DATA_W)) u_latch (
      .cs_n      (cs_n),
      .sample_in (sample_word),
      .word_q    (word_q)
   );

   sar_emu_out_sel #(
      .DATA_W(DATA_W), .SAMPLE_EDGES(SAMPLE_EDGES), .NULL_BITS(NULL_BITS),
      .REPEAT_LSB(REPEAT_LSB), .CNT_W(CNT_W)
   ) u_sel (
      .cs_n   (cs_n),
      .cnt    (edge_cnt),
      .word_q (word_q),
      .sdo    (sdo),
      .sdo_en (sdo_en),
      .pwr    (pwr)
   );

   assign pwr_state = pwr;
endmodule

// File: rtl/sar_serial_emu_chk.sv
`timescale 1ns/1ps
module sar_serial_emu_chk #(
   parameter int DATA_W       = 16,
   parameter int SAMPLE_EDGES = 5,
   parameter int NULL_BITS    = 1,
   parameter bit REPEAT_LSB   = 1'b1,
   parameter int CNT_W        = 6
) (
   input logic              dclk,
   input logic              cs_n,
   input logic              sdo,
   input logic              sdo_en,
   input logic [1:0]        pwr_state,
   input logic [CNT_W-1:0]  cnt,
   input logic [DATA_W-1:0] word_q
);
   localparam int END_CNT = sar_emu_pkg::frame_end(DATA_W, SAMPLE_EDGES, NULL_BITS, REPEAT_LSB);
   localparam logic [CNT_W-1:0] SAMPLE_C = CNT_W'(SAMPLE_EDGES);
   localparam logic [CNT_W-1:0] END_C    = CNT_W'(END_CNT);
   localparam logic [CNT_W-1:0] ONE_C    = CNT_W'(1);

   always_comb begin
      if (cs_n === 1'b1)
         assert_idle_when_high_R1: assert (!sdo_en && pwr_state == 2'b10);
   end

   assert_quiet_sampling_R3: assert property (@(posedge dclk) disable iff (cs_n)
      (cnt < SAMPLE_C) |-> !sdo_en);

   assert_null_first_R4: assert property (@(posedge dclk) disable iff (cs_n)
      $rose(sdo_en) |-> !sdo);

   assert_word_held_R2: assert property (@(posedge dclk) disable iff (cs_n)
      (cnt > ONE_C) |-> $stable(word_q));

   assert_end_released_R7: assert property (@(posedge dclk) disable iff (cs_n)
      (cnt == END_C) |=> !sdo_en);

   assert_power_sticky_R8: assert property (@(posedge dclk) disable iff (cs_n)
      (pwr_state == 2'b01) |=> (pwr_state == 2'b01));
endmodule

bind sar_serial_emu sar_serial_emu_chk #(
   .DATA_W(DATA_W), .SAMPLE_EDGES(SAMPLE_EDGES), .NULL_BITS(NULL_BITS),
   .REPEAT_LSB(REPEAT_LSB), .CNT_W(CNT_W)
) u_chk (
   .dclk(dclk), .cs_n(cs_n), .sdo(sdo), .sdo_en(sdo_en),
   .pwr_state(pwr_state), .cnt(edge_cnt), .word_q(word_q)
);

// File: tb/tb_sar_serial_emu.sv
`timescale 1ns/1ps
module tb_sar_serial_emu;
   logic        dclk = 1'b0;
   logic        cs_n = 1'b0;
   logic [15:0] sample_word = 16'h0000;
   logic        sdo, sdo_en;
   logic [1:0]  pwr_state;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   sar_serial_emu dut (
      .dclk(dclk), .cs_n(cs_n), .sample_word(sample_word),
      .sdo(sdo), .sdo_en(sdo_en), .pwr_state(pwr_state)
   );

   always #5 dclk = ~dclk;

   function automatic bit exp_en(input int e);
      return (e >= 5) && (e <= 36);
   endfunction

   function automatic bit exp_bit(input logic [15:0] w, input int e);
      if (e >= 6 && e <= 21) return w[21 - e];
      if (e >= 22 && e <= 36) return w[e - 21];
      return 1'b0;
   endfunction

   function automatic logic [1:0] exp_pwr(input int e);
      return (e >= 21) ? 2'b01 : 2'b00;
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_edge(input logic [15:0] w, input int e);
      string r;
      r = (e < 5) ? "R3" : (e == 5) ? "R4" : (e <= 21) ? "R5" : (e <= 36) ? "R6" : "R7";
      check(r, {15'd0, sdo_en}, {15'd0, exp_en(e)});
      if (exp_en(e)) check(r, {15'd0, sdo}, {15'd0, exp_bit(w, e)});
      check("R8", {14'd0, pwr_state}, {14'd0, exp_pwr(e)});
   endtask

   // stop_at: edge at which cs_n rises (same instant as the edge); >40 runs to completion
   task automatic frame(input logic [15:0] w, input int stop_at, input bit scramble);
      bit stopped = 1'b0;
      sample_word = w;
      @(posedge dclk);
      #1 cs_n = 1'b0;
      #1 check_edge(w, 0);
      for (int e = 1; e <= 40; e++) begin
         @(negedge dclk);
         if (e == stop_at) begin
            cs_n = 1'b1;
            #2;
            check("R1", {14'd0, pwr_state, sdo_en}, {14'd0, 2'b10, 1'b0});
            stopped = 1'b1;
            break;
         end
         #2 check_edge(w, e);
         if (scramble && e == 3) sample_word = ~w;   // R2: update mid-frame
      end
      if (!stopped) begin
         @(negedge dclk);
         cs_n = 1'b1;
         #2 check("R1", {14'd0, pwr_state, sdo_en}, {14'd0, 2'b10, 1'b0});
      end
      @(posedge dclk);
   endtask

   initial begin
      void'($urandom(32'h5EED_0042));
      #3 cs_n = 1'b1;
      #3 check("R1", {14'd0, pwr_state, sdo_en}, {14'd0, 2'b10, 1'b0});
      frame(16'h0000, 99, 1'b0);
      frame(16'h8000, 99, 1'b0);
      frame(16'hFFFF, 99, 1'b0);
      frame(16'h7FFF, 99, 1'b0);
      frame(16'hA5C3, 99, 1'b1);           // R2 word held despite update
      frame(16'h1234, 14, 1'b0);           // R1 short cycle mid word
      frame(16'h0F0F, 3, 1'b0);            // R1 abort during sampling
      frame(16'hC001, 99, 1'b0);           // R9 fresh frame after abort
      frame(16'h8001, 22, 1'b0);           // R1 abort at start of repeat
      for (int i = 0; i < 30; i++) begin
         logic [15:0] w;
         int stop;
         w = 16'($urandom);
         stop = ($urandom % 3 == 0) ? int'(1 + $urandom % 39) : 99;
         frame(w, stop, 1'($urandom % 2));  // R9 back-to-back frames
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge dclk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule